// File: doc/BRIEF.md
# Control endpoint handshake register block

This block keeps the small amount of state that governs endpoint zero of a USB function: a flag that records an arrived SETUP packet, a two-bit response mode, a buffer-valid bit and a hidden data-toggle bit. Firmware reaches the three visible registers through a simple byte-wide register port. The serial interface engine reports events on its own port: SETUP received, transaction completed, control-transfer error. It also presents the current token, and gets back the handshake to send, the data PID to use and a permission to touch the endpoint buffer.

Hardware events are applied after the CPU write in the same cycle, so on any bit they both target the hardware value is what lands. A SETUP packet is always accepted, re-arms the endpoint in a known state and sets the toggle to DATA1. An error forces the endpoint into stall until firmware or the next SETUP packet clears it.

Top module: `ep0_hs_ctrl`

## Requirements
- R1: A SETUP event (`ev_setup` high for a cycle) sets the setup flag, which reads as bit 0 of register address 0 from the next cycle.
- R2: A CPU write to address 0 with data bit 0 equal to 0 clears the setup flag, except when `ev_setup` is high in the same cycle. Writing bit 0 as 1 leaves the flag unchanged.
- R3: The mode field is bits 1:0 of address 1. For IN (`tok_kind`=00 for OUT, 01 for IN) tokens and OUT tokens, mode 00 answers NAK and mode 1x answers STALL. Mode 01 is automatic. Handshake codes on `hs_resp`: 00 none, 01 ACK, 10 NAK, 11 STALL.
- R4: An error event sets mode bit 1 and keeps bit 0. If a SETUP event arrives in the same cycle, the SETUP result is what remains.
- R5: A SETUP event clears the mode field and the buffer-valid bit, and makes `data_pid_one` 1 (DATA1) from the next cycle.
- R6: The buffer-valid bit is bit 0 of address 2. In automatic mode with it at 0, IN and OUT tokens get NAK and `buf_access` is 0. With it at 1, they get ACK and `buf_access` is 1.
- R7: A SETUP token (`tok_kind`=10) is answered with ACK and `buf_access`=1 whatever the mode and buffer-valid state.
- R8: A completion (`ev_done`) of a transaction answered with ACK and buffer access inverts `data_pid_one` and clears the buffer-valid bit.
- R9: In automatic mode with the buffer valid, an OUT whose `tok_pid_one` differs from `data_pid_one` gets ACK with `buf_access`=0. Its completion changes neither the toggle nor the buffer-valid bit.
- R10: After reset all registers read 0, `data_pid_one` is 0 and `hs_resp` is 00 with no token. Unused register bits and address 3 read 0, and writes to them are dropped.
- R11: When a completion and a CPU write of 1 hit the buffer-valid bit together, it ends at 0. When an error and a CPU write of 00 hit the mode together, it ends at 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for `cpu_addr` (combinational) |
| tok_vld | input | 1 | A token is being answered this cycle |
| tok_kind | input | 2 | Token kind: 00 OUT, 01 IN, 10 SETUP |
| tok_pid_one | input | 1 | Received data PID of an OUT packet is DATA1 |
| ev_setup | input | 1 | SETUP packet received (one-cycle pulse) |
| ev_done | input | 1 | Current transaction completed (pulse, token still presented) |
| ev_err | input | 1 | Control-transfer error (pulse) |
| hs_resp | output | 2 | Handshake to send |
| data_pid_one | output | 1 | Data PID to use is DATA1 |
| buf_access | output | 1 | Engine may read or write the endpoint buffer |

## Verification
A stale mode or buffer-valid bit shows in the same cycle on `hs_resp` and `buf_access` for the next token, because the response path is purely combinational from the registers. A wrong toggle shows at once on `data_pid_one`. It also turns a correct OUT into a silently discarded one, visible as ACK without buffer access. Priority errors between hardware and CPU show on the register readback one cycle after the collision. The bench sweeps every mode, buffer-valid, toggle, token kind and received PID combination and provokes each collision on purpose.

// File: rtl/ep0_hs_pkg.sv
package ep0_hs_pkg;

    localparam int REG_AW = 2;
    localparam int REG_DW = 8;

    localparam logic [REG_AW-1:0] ADDR_STAGE = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_MODE  = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_VALID = 2'd2;

    typedef enum logic [1:0] {
        TK_OUT   = 2'b00,
        TK_IN    = 2'b01,
        TK_SETUP = 2'b10,
        TK_RSVD  = 2'b11
    } tok_kind_e;

    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_e;

    typedef struct packed {
        logic       flag;
        logic [1:0] mode;
        logic       bval;
    } ep_state_t;

    typedef struct packed {
        logic setup;
        logic err;
        logic done_ok;
    } hw_ev_t;

    function automatic logic mode_is_stall(input logic [1:0] m);
        return m[1];
    endfunction

    function automatic logic mode_is_auto(input logic [1:0] m);
        return (m == 2'b01);
    endfunction

endpackage

// File: rtl/ep0_regs.sv
module ep0_regs
    import ep0_hs_pkg::*;
#(
    parameter int AW = REG_AW,
    parameter int DW = REG_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  hw_ev_t        ev,
    output ep_state_t     st
);

    localparam int PADW_1 = DW - 1;
    localparam int PADW_2 = DW - 2;

    ep_state_t nx;
    logic      unused_hi;
    assign unused_hi = ^wdata[DW-1:2];

    // CPU write first, hardware events layered on top so they win per bit
    always_comb begin
        nx = st;
        if (we) begin
            unique case (addr)
                AW'(ADDR_STAGE): if (!wdata[0]) nx.flag = 1'b0;
                AW'(ADDR_MODE):  nx.mode = wdata[1:0];
                AW'(ADDR_VALID): nx.bval = wdata[0];
                default: ;
            endcase
        end
        if (ev.done_ok) nx.bval    = 1'b0;
        if (ev.err)     nx.mode[1] = 1'b1;
        if (ev.setup) begin
            nx.flag = 1'b1;
            nx.mode = 2'b00;
            nx.bval = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nx;
    end

    always_comb begin
        unique case (addr)
            AW'(ADDR_STAGE): rdata = {{PADW_1{1'b0}}, st.flag};
            AW'(ADDR_MODE):  rdata = {{PADW_2{1'b0}}, st.mode};
            AW'(ADDR_VALID): rdata = {{PADW_1{1'b0}}, st.bval};
            default:         rdata = '0;
        endcase
    end

    assert_setup_sets_flag_R1: assert property (@(posedge clk) disable iff (rst)
        ev.setup |=> st.flag);

    assert_flag_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (we && addr == AW'(ADDR_STAGE) && !wdata[0] && !ev.setup) |=> !st.flag);

    assert_flag_w1_keeps_R2: assert property (@(posedge clk) disable iff (rst)
        (we && addr == AW'(ADDR_STAGE) && wdata[0] && !ev.setup)
        |=> st.flag == $past(st.flag));

    assert_err_stalls_R4: assert property (@(posedge clk) disable iff (rst)
        (ev.err && !ev.setup) |=> st.mode[1]);

    assert_setup_clears_R5: assert property (@(posedge clk) disable iff (rst)
        ev.setup |=> (st.mode == 2'b00 && !st.bval));

    assert_done_beats_cpu_R11: assert property (@(posedge clk) disable iff (rst)
        ev.done_ok |=> !st.bval);

endmodule

// File: rtl/ep0_toggle.sv
module ep0_toggle (
    input  logic clk,
    input  logic rst,
    input  logic setup,
    input  logic adv,
    output logic tog
);

    always_ff @(posedge clk) begin
        if (rst)        tog <= 1'b0;
        else if (setup) tog <= 1'b1;
        else if (adv)   tog <= ~tog;
    end

    assert_setup_data1_R5: assert property (@(posedge clk) disable iff (rst)
        setup |=> tog);

    assert_adv_flips_R8: assert property (@(posedge clk) disable iff (rst)
        (adv && !setup) |=> tog != $past(tog));

    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (!adv && !setup) |=> $stable(tog));

endmodule

// File: rtl/ep0_resp.sv
module ep0_resp
    import ep0_hs_pkg::*;
(
    input  logic       tok_vld,
    input  tok_kind_e  kind,
    input  logic       rx_pid_one,
    input  logic [1:0] mode,
    input  logic       bval,
    input  logic       tog,
    output hs_e        hs,
    output logic       buf_en,
    output logic       xfer_ok
);

    logic data_tok;
    logic toggle_bad;

    assign data_tok   = (kind == TK_OUT) || (kind == TK_IN);
    assign toggle_bad = (kind == TK_OUT) && (rx_pid_one != tog);

    always_comb begin
        hs      = HS_NONE;
        buf_en  = 1'b0;
        xfer_ok = 1'b0;
        if (tok_vld) begin
            if (kind == TK_SETUP) begin
                hs     = HS_ACK;
                buf_en = 1'b1;
            end else if (data_tok) begin
                if (mode_is_stall(mode)) begin
                    hs = HS_STALL;
                end else if (!mode_is_auto(mode) || !bval) begin
                    hs = HS_NAK;
                end else if (toggle_bad) begin
                    hs = HS_ACK;
                end else begin
                    hs      = HS_ACK;
                    buf_en  = 1'b1;
                    xfer_ok = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ep0_hs_ctrl.sv
module ep0_hs_ctrl
    import ep0_hs_pkg::*;
#(
    parameter int AW = REG_AW,
    parameter int DW = REG_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    input  logic          tok_vld,
    input  logic [1:0]    tok_kind,
    input  logic          tok_pid_one,
    input  logic          ev_setup,
    input  logic          ev_done,
    input  logic          ev_err,
    output logic [1:0]    hs_resp,
    output logic          data_pid_one,
    output logic          buf_access
);

    ep_state_t st;
    hw_ev_t    ev;
    hs_e       hs;
    tok_kind_e kind;
    logic      xfer_ok;
    logic      tog;
    logic      advance;

    assign kind    = tok_kind_e'(tok_kind);
    assign advance = ev_done && xfer_ok;

    assign ev.setup   = ev_setup;
    assign ev.err     = ev_err;
    assign ev.done_ok = advance;

    ep0_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cpu_we),
        .addr  (cpu_addr),
        .wdata (cpu_wdata),
        .rdata (cpu_rdata),
        .ev    (ev),
        .st    (st)
    );

    ep0_toggle u_tog (
        .clk   (clk),
        .rst   (rst),
        .setup (ev_setup),
        .adv   (advance),
        .tog   (tog)
    );

    ep0_resp u_resp (
        .tok_vld    (tok_vld),
        .kind       (kind),
        .rx_pid_one (tok_pid_one),
        .mode       (st.mode),
        .bval       (st.bval),
        .tog        (tog),
        .hs         (hs),
        .buf_en     (buf_access),
        .xfer_ok    (xfer_ok)
    );

    assign hs_resp      = hs;
    assign data_pid_one = tog;

    logic unused_flag;
    assign unused_flag = st.flag;

    assert_stall_mode_R3: assert property (@(posedge clk) disable iff (rst)
        (tok_vld && (kind == TK_OUT || kind == TK_IN) && st.mode[1])
        |-> (hs_resp == 2'b11 && !buf_access));

    assert_nak_no_buf_R6: assert property (@(posedge clk) disable iff (rst)
        (hs_resp == 2'b10) |-> !buf_access);

    assert_setup_ack_R7: assert property (@(posedge clk) disable iff (rst)
        (tok_vld && kind == TK_SETUP) |-> (hs_resp == 2'b01 && buf_access));

    assert_discard_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        (ev_done && !buf_access && !ev_setup) |=> $stable(data_pid_one));

endmodule

// File: tb/sim_ep0_hs_ctrl.sv
`timescale 1ns/1ps
module sim_ep0_hs_ctrl;

    localparam int WD_NS = 500_000;
    localparam logic [1:0] C_NONE = 2'b00, C_ACK = 2'b01, C_NAK = 2'b10, C_STALL = 2'b11;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_we = 1'b0;
    logic [1:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       tok_vld = 1'b0;
    logic [1:0] tok_kind = '0;
    logic       tok_pid_one = 1'b0;
    logic       ev_setup = 1'b0, ev_done = 1'b0, ev_err = 1'b0;
    logic [1:0] hs_resp;
    logic       data_pid_one, buf_access;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ep0_hs_ctrl u0 (
        .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .tok_vld(tok_vld),
        .tok_kind(tok_kind), .tok_pid_one(tok_pid_one), .ev_setup(ev_setup),
        .ev_done(ev_done), .ev_err(ev_err), .hs_resp(hs_resp),
        .data_pid_one(data_pid_one), .buf_access(buf_access)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; step(); step(); rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        step();
        cpu_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input int exp);
        cpu_addr = a; #0.5;
        chk(req, cpu_rdata, exp);
    endtask

    task automatic pulse_setup();
        ev_setup = 1'b1; step(); ev_setup = 1'b0;
    endtask

    // {hs, buf} expected from the requirements
    function automatic logic [2:0] exp_resp(int md, int bv, int kd, int rx, int tg);
        if (kd == 2)                  return {C_ACK, 1'b1};
        if (md >= 2)                  return {C_STALL, 1'b0};
        if (md == 0 || bv == 0)       return {C_NAK, 1'b0};
        if (kd == 0 && rx != tg)      return {C_ACK, 1'b0};
        return {C_ACK, 1'b1};
    endfunction

    initial begin
        #(WD_NS);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10: reset state
        for (int a = 0; a < 4; a++) rd_chk("R10 reset read", 2'(a), 0);
        chk("R10 reset pid", data_pid_one, 0);
        chk("R10 idle hs", hs_resp, C_NONE);

        // R1 / R5 / R7
        wr(2'd1, 8'h03); wr(2'd2, 8'h01);
        pulse_setup();
        rd_chk("R1 flag set", 2'd0, 1);
        rd_chk("R5 mode cleared", 2'd1, 0);
        rd_chk("R5 bval cleared", 2'd2, 0);
        chk("R5 pid DATA1", data_pid_one, 1);
        wr(2'd1, 8'h02);
        tok_vld = 1'b1; tok_kind = 2'b10; #0.5;
        chk("R7 setup ack in stall", hs_resp, C_ACK);
        chk("R7 setup buf", buf_access, 1);
        tok_vld = 1'b0;

        // R2
        wr(2'd0, 8'hFF);
        rd_chk("R2 write1 keeps", 2'd0, 1);
        ev_setup = 1'b1; wr(2'd0, 8'h00); ev_setup = 1'b0;
        rd_chk("R2 clear blocked by setup", 2'd0, 1);
        wr(2'd0, 8'hFE);
        rd_chk("R2 write0 clears", 2'd0, 0);
        wr(2'd0, 8'h01);
        rd_chk("R2 write1 no set", 2'd0, 0);

        // R10: unused bits and unmapped address
        wr(2'd1, 8'hFC);
        rd_chk("R10 mode upper dropped", 2'd1, 0);
        wr(2'd2, 8'hFE);
        rd_chk("R10 valid upper dropped", 2'd2, 0);
        wr(2'd3, 8'hFF);
        rd_chk("R10 addr3 zero", 2'd3, 0);
        rd_chk("R10 addr3 no side effect", 2'd1, 0);

        // R3 / R6 / R7 / R9: sweep
        for (int tg = 0; tg < 2; tg++)
            for (int md = 0; md < 4; md++)
                for (int bv = 0; bv < 2; bv++) begin
                    do_reset();
                    if (tg == 1) pulse_setup();
                    wr(2'd1, 8'(md)); wr(2'd2, 8'(bv));
                    for (int kd = 0; kd < 3; kd++)
                        for (int rx = 0; rx < 2; rx++) begin
                            logic [2:0] e;
                            e = exp_resp(md, bv, kd, rx, tg);
                            tok_vld = 1'b1; tok_kind = 2'(kd); tok_pid_one = 1'(rx); #0.5;
                            chk("R3 R6 R9 sweep hs", hs_resp, e[2:1]);
                            chk("R6 R7 sweep buf", buf_access, e[0]);
                            chk("R5 sweep pid", data_pid_one, tg);
                        end
                    tok_vld = 1'b0;
                end

        // R8: accepted transactions advance
        do_reset(); pulse_setup();
        wr(2'd1, 8'h01); wr(2'd2, 8'h01);
        tok_vld = 1'b1; tok_kind = 2'b01; ev_done = 1'b1; step(); ev_done = 1'b0; tok_vld = 1'b0;
        chk("R8 IN flips pid", data_pid_one, 0);
        rd_chk("R8 IN clears bval", 2'd2, 0);
        wr(2'd2, 8'h01);
        tok_vld = 1'b1; tok_kind = 2'b00; tok_pid_one = 1'b0;
        ev_done = 1'b1; step(); ev_done = 1'b0; tok_vld = 1'b0;
        chk("R8 OUT flips pid", data_pid_one, 1);
        rd_chk("R8 OUT clears bval", 2'd2, 0);
        // R9: mismatched toggle discarded
        wr(2'd2, 8'h01);
        tok_vld = 1'b1; tok_kind = 2'b00; tok_pid_one = 1'b0; #0.5;
        chk("R9 mismatch ack", hs_resp, C_ACK);
        chk("R9 mismatch no buf", buf_access, 0);
        ev_done = 1'b1; step(); ev_done = 1'b0; tok_vld = 1'b0;
        chk("R9 pid kept", data_pid_one, 1);
        rd_chk("R9 bval kept", 2'd2, 1);
        // NAK completion changes nothing
        wr(2'd1, 8'h00);
        tok_vld = 1'b1; tok_kind = 2'b01; ev_done = 1'b1; step(); ev_done = 1'b0; tok_vld = 1'b0;
        chk("R8 nak done pid kept", data_pid_one, 1);
        rd_chk("R8 nak done bval kept", 2'd2, 1);

        // R4
        wr(2'd1, 8'h01);
        ev_err = 1'b1; step(); ev_err = 1'b0;
        rd_chk("R4 err sets bit1", 2'd1, 3);
        ev_err = 1'b1; ev_setup = 1'b1; step(); ev_err = 1'b0; ev_setup = 1'b0;
        rd_chk("R4 setup beats err", 2'd1, 0);

        // R11: hardware beats CPU
        wr(2'd1, 8'h01); wr(2'd2, 8'h01);
        tok_vld = 1'b1; tok_kind = 2'b01; ev_done = 1'b1;
        wr(2'd2, 8'h01);
        ev_done = 1'b0; tok_vld = 1'b0;
        rd_chk("R11 done beats write", 2'd2, 0);
        ev_err = 1'b1; wr(2'd1, 8'h00); ev_err = 1'b0;
        rd_chk("R11 err beats write", 2'd1, 2);
        ev_setup = 1'b1; wr(2'd2, 8'h01); ev_setup = 1'b0;
        rd_chk("R11 setup beats valid write", 2'd2, 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule